// File: doc/BRIEF.md
# Address Match Trigger Comparator

This block watches the instruction fetch stream and the load/store stream of a core and compares each against a small set of hardware triggers. Every trigger supplies a control word and a compare value. If an enabled trigger matches the current fetch address or data access in the current privilege mode, the block raises a breakpoint request so that the pipeline can take a breakpoint exception before that instruction or access has any effect.

Fetch matching uses exact address equality. Data matching uses an address window. The window starts at the compare value and its width comes from the size field of the control word. The fetch check and the data check are evaluated in parallel in every cycle. The result is registered and is presented one cycle after the strobes, as a single-cycle hit pulse. The pulse carries the index of the lowest-numbered trigger that matched and the breakpoint exception cause code.

The control word layout used by every trigger is as follows:
- bit 0: load enable
- bit 1: store enable
- bit 2: execute enable
- bit 3: user-mode enable
- bit 4: supervisor-mode enable
- bit 6: machine-mode enable
- bits 17:16: size field

All other bits are ignored.

Top module: `trig_match`

## Requirements
- R1: A trigger can hit only when at least one of its mode bits (3, 4, 6) is set and at least one of its access-kind bits (0, 1, 2) is set.
- R2: An execute hit requires control bit 2, fetch_valid_i high, and fetch_pc_i exactly equal to the trigger's compare value.
- R3: A data hit requires load bit 0 together with data_rd_i, or store bit 1 together with data_wr_i, with data_addr_i inside the trigger's window.
- R4: The privilege level on priv_i selects which control bit must be set: 0 (user) selects bit 3, 1 (supervisor) selects bit 4, and 3 (machine) selects bit 6. The reserved value 2 never hits.
- R5: The size field at bits 17:16 sets the window width: 0 means 8 bytes, 1 means 1 byte, 2 means 2 bytes, and 3 means 4 bytes.
- R6: An address is inside the window when (data_addr_i − compare value), taken modulo 2^XLEN, is less than the window width. A window placed near the top of the address space therefore wraps to address zero.
- R7: When several triggers hit in one cycle, whether through the fetch check or the data check, hit_idx_o reports the lowest index.
- R8: hit_o is asserted in the cycle after the matching strobes and only for that one cycle. With all strobes low, no hit is produced.
- R9: Whenever hit_o is high, cause_o equals 3. In all other cycles cause_o is 0.
- R10: After reset, hit_o, hit_idx_o and cause_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | A fetch address is present |
| fetch_pc_i | input | XLEN | Fetch address |
| data_rd_i | input | 1 | A load access is present |
| data_wr_i | input | 1 | A store access is present |
| data_addr_i | input | XLEN | Load/store address |
| priv_i | input | 2 | Current privilege level |
| tctrl_i | input | NUM_TRIG*XLEN | Control words, with trigger k at bits [k*XLEN +: XLEN] |
| tcmp_i | input | NUM_TRIG*XLEN | Compare values, packed in the same way |
| hit_o | output | 1 | Breakpoint request pulse |
| hit_idx_o | output | IDX_W | Index of the trigger reported as hitting |
| cause_o | output | 4 | Exception cause code (3 during a hit) |

## Verification
The execute match and the data match can both occur in the same cycle, either on a single trigger or on different triggers. The bench provokes this in two ways. First, it raises a fetch strobe and load/store strobes together inside the main sweep. Second, it points trigger 1 at the fetch address and trigger 0 at the data window, and then swaps the two. The outcome is judged against an arithmetic model: hit_o must be the OR of both matches, and hit_idx_o must name the lowest index, whichever kind of match produced it.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;
  localparam int LD_BIT   = 0;
  localparam int ST_BIT   = 1;
  localparam int EX_BIT   = 2;
  localparam int U_BIT    = 3;
  localparam int S_BIT    = 4;
  localparam int M_BIT    = 6;
  localparam int SIZE_LSB = 16;
  localparam int SIZE_W   = 2;
  localparam int CAUSE_W  = 4;
  localparam logic [CAUSE_W-1:0] BKPT_CAUSE = 4'd3;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;
endpackage

// File: rtl/trig_slot.sv
module trig_slot
  import trig_match_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] ctrl_i,
  input  logic [XLEN-1:0] cmp_i,
  input  logic            fetch_valid_i,
  input  logic [XLEN-1:0] fetch_pc_i,
  input  logic            data_rd_i,
  input  logic            data_wr_i,
  input  logic [XLEN-1:0] data_addr_i,
  input  logic [1:0]      priv_i,
  output logic            hit_o
);
  localparam int WIN_W = 4;

  logic             mode_any, kind_any, priv_ok;
  logic [WIN_W-1:0] win_bytes;
  logic [XLEN-1:0]  offs;
  logic             in_win, ex_hit, ld_hit, st_hit;

  assign mode_any = ctrl_i[U_BIT] | ctrl_i[S_BIT] | ctrl_i[M_BIT];
  assign kind_any = ctrl_i[LD_BIT] | ctrl_i[ST_BIT] | ctrl_i[EX_BIT];

  always_comb begin
    unique case (priv_e'(priv_i))
      PRIV_U:  priv_ok = ctrl_i[U_BIT];
      PRIV_S:  priv_ok = ctrl_i[S_BIT];
      PRIV_M:  priv_ok = ctrl_i[M_BIT];
      default: priv_ok = 1'b0;
    endcase
  end

  // size 0 watches a double-word
  always_comb begin
    unique case (ctrl_i[SIZE_LSB +: SIZE_W])
      2'd1:    win_bytes = 4'd1;
      2'd2:    win_bytes = 4'd2;
      2'd3:    win_bytes = 4'd4;
      default: win_bytes = 4'd8;
    endcase
  end

  // modular distance handles windows that wrap past the top
  assign offs   = data_addr_i - cmp_i;
  assign in_win = offs < XLEN'(win_bytes);

  assign ex_hit = fetch_valid_i & ctrl_i[EX_BIT] & (fetch_pc_i == cmp_i);
  assign ld_hit = data_rd_i & ctrl_i[LD_BIT] & in_win;
  assign st_hit = data_wr_i & ctrl_i[ST_BIT] & in_win;

  assign hit_o = mode_any & kind_any & priv_ok & (ex_hit | ld_hit | st_hit);

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_i[XLEN-1:SIZE_LSB+SIZE_W], ctrl_i[SIZE_LSB-1:M_BIT+1],
                         ctrl_i[M_BIT-1:S_BIT+1]};
endmodule

// File: rtl/trig_pick.sv
module trig_pick #(
  parameter int N     = 2,
  parameter int IDX_W = 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o = |req_i;

  // scan downward so the lowest index wins
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IDX_W'(k);
    end
  end
endmodule

// File: rtl/trig_match.sv
module trig_match
  import trig_match_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 2,
  parameter int IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fetch_valid_i,
  input  logic [XLEN-1:0]          fetch_pc_i,
  input  logic                     data_rd_i,
  input  logic                     data_wr_i,
  input  logic [XLEN-1:0]          data_addr_i,
  input  logic [1:0]               priv_i,
  input  logic [NUM_TRIG*XLEN-1:0] tctrl_i,
  input  logic [NUM_TRIG*XLEN-1:0] tcmp_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         hit_idx_o,
  output logic [CAUSE_W-1:0]       cause_o
);
  logic [NUM_TRIG-1:0] slot_hit;
  logic                any_hit;
  logic [IDX_W-1:0]    pick_idx;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
    trig_slot #(.XLEN(XLEN)) u_slot (
      .ctrl_i        (tctrl_i[g*XLEN +: XLEN]),
      .cmp_i         (tcmp_i[g*XLEN +: XLEN]),
      .fetch_valid_i (fetch_valid_i),
      .fetch_pc_i    (fetch_pc_i),
      .data_rd_i     (data_rd_i),
      .data_wr_i     (data_wr_i),
      .data_addr_i   (data_addr_i),
      .priv_i        (priv_i),
      .hit_o         (slot_hit[g])
    );
  end

  trig_pick #(.N(NUM_TRIG), .IDX_W(IDX_W)) u_pick (
    .req_i (slot_hit),
    .any_o (any_hit),
    .idx_o (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
      cause_o   <= '0;
    end else begin
      hit_o     <= any_hit;
      hit_idx_o <= any_hit ? pick_idx : '0;
      cause_o   <= any_hit ? BKPT_CAUSE : '0;
    end
  end
endmodule

// File: rtl/trig_match_chk.sv
module trig_match_chk
  import trig_match_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 2,
  parameter int IDX_W    = 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     fetch_valid_i,
  input logic                     data_rd_i,
  input logic                     data_wr_i,
  input logic [1:0]               priv_i,
  input logic [NUM_TRIG*XLEN-1:0] tctrl_i,
  input logic                     hit_o,
  input logic [IDX_W-1:0]         hit_idx_o,
  input logic [CAUSE_W-1:0]       cause_o
);
  logic [NUM_TRIG*XLEN-1:0] prev_ctrl;
  logic [1:0]               prev_priv;
  logic [XLEN-1:0]          rep_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ctrl <= '0;
      prev_priv <= '0;
    end else begin
      prev_ctrl <= tctrl_i;
      prev_priv <= priv_i;
    end
  end

  assign rep_ctrl = prev_ctrl[hit_idx_o*XLEN +: XLEN];

  a_r1_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((rep_ctrl[U_BIT] | rep_ctrl[S_BIT] | rep_ctrl[M_BIT]) &&
               (rep_ctrl[LD_BIT] | rep_ctrl[ST_BIT] | rep_ctrl[EX_BIT])));

  a_r4_priv_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (prev_priv != 2'd2 && rep_ctrl[U_BIT + prev_priv]));

  a_r8_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_valid_i | data_rd_i | data_wr_i) |=> !hit_o);

  a_r9_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> cause_o == BKPT_CAUSE);

  a_r9_cause_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> cause_o == '0);
endmodule

bind trig_match trig_match_chk #(
  .XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .data_rd_i     (data_rd_i),
  .data_wr_i     (data_wr_i),
  .priv_i        (priv_i),
  .tctrl_i       (tctrl_i),
  .hit_o         (hit_o),
  .hit_idx_o     (hit_idx_o),
  .cause_o       (cause_o)
);

// File: tb/trig_match_bench.sv
`timescale 1ns/1ps
module trig_match_bench;
  localparam int XLEN = 32;
  localparam int NT   = 2;
  localparam int IW   = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fv = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [XLEN-1:0] pc = '0, addr = '0;
  logic [1:0] priv = '0;
  logic [XLEN-1:0] ctl0 = '0, ctl1 = '0, cmp0 = '0, cmp1 = '0;
  logic hit;
  logic [IW-1:0] idx;
  logic [3:0] cause;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_match #(.XLEN(XLEN), .NUM_TRIG(NT)) u_trig_match (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_pc_i(pc),
    .data_rd_i(rd), .data_wr_i(wr), .data_addr_i(addr), .priv_i(priv),
    .tctrl_i({ctl1, ctl0}), .tcmp_i({cmp1, cmp0}),
    .hit_o(hit), .hit_idx_o(idx), .cause_o(cause)
  );

  function automatic bit model(input logic [XLEN-1:0] c, input logic [XLEN-1:0] b,
                               input bit f, input logic [XLEN-1:0] p, input bit r,
                               input bit w, input logic [XLEN-1:0] a, input int pv);
    int sz;
    bit en, pm, x, d;
    logic [XLEN-1:0] off;
    en = (c[3] | c[4] | c[6]) && (c[0] | c[1] | c[2]);
    pm = (pv != 2) && c[3 + pv];
    sz = (c[17:16] == 2'd0) ? 8 : (1 << (c[17:16] - 1));
    off = a - b;
    x = f && c[2] && (p == b);
    d = ((r && c[0]) || (w && c[1])) && (off < XLEN'(sz));
    return en && pm && (x || d);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit f, input logic [XLEN-1:0] p, input bit r, input bit w,
                      input logic [XLEN-1:0] a, input string req);
    bit h0, h1, eh;
    int ei;
    @(negedge clk);
    fv = f; pc = p; rd = r; wr = w; addr = a;
    h0 = model(ctl0, cmp0, f, p, r, w, a, int'(priv));
    h1 = model(ctl1, cmp1, f, p, r, w, a, int'(priv));
    eh = h0 | h1;
    ei = h0 ? 0 : (h1 ? 1 : 0);
    @(posedge clk); #1;
    chk(req, 32'(hit), 32'(eh));
    if (eh) begin
      chk({req, "_R7_idx"}, 32'(idx), 32'(ei));
      chk("R9_cause", 32'(cause), 32'd3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] base;
    repeat (3) @(posedge clk); #1;
    chk("R10_hit", 32'(hit), 0);
    chk("R10_idx", 32'(idx), 0);
    chk("R10_cause", 32'(cause), 0);
    rst_n = 1'b1;

    // main sweep on trigger 0: mode bits x kind bits x size x privilege
    base = 32'h1000_0040;
    cmp0 = base; cmp1 = 32'h7000_0000; ctl1 = '0;
    for (int cfg = 0; cfg < 256; cfg++) begin
      for (int pv = 0; pv < 4; pv++) begin
        @(negedge clk);
        ctl0 = '0;
        ctl0[3] = cfg[0]; ctl0[4] = cfg[1]; ctl0[6] = cfg[2];
        ctl0[2:0] = 3'(cfg >> 3);
        ctl0[17:16] = 2'(cfg >> 6);
        priv = 2'(pv);
        step(1, base, 0, 0, '0, "R2_exec");
        step(1, base + 4, 0, 0, '0, "R2_exec_miss");
        for (int o = -1; o <= 8; o++) begin
          step(0, '0, 1, 0, base + XLEN'(o), "R3_R5_load");
          step(0, '0, 0, 1, base + XLEN'(o), "R3_R5_store");
        end
        step(1, base, 1, 1, base + 2, "R1_R4_both");
        step(0, '0, 0, 0, base, "R8_idle");
      end
    end

    // wrapping window: 8 bytes from near the top of the space
    priv = 2'd3;
    ctl0 = 32'h0000_0043; cmp0 = 32'hFFFF_FFFC;
    step(0, '0, 1, 0, 32'h0000_0003, "R6_wrap_in");
    step(0, '0, 1, 0, 32'h0000_0004, "R6_wrap_out");
    step(0, '0, 1, 0, 32'hFFFF_FFFB, "R6_below");

    // fetch and data in one cycle across triggers
    ctl0 = 32'h0000_0041; cmp0 = 32'h0000_2000;
    ctl1 = 32'h0000_0044; cmp1 = 32'h0000_3000;
    step(1, 32'h3000, 1, 0, 32'h2004, "R7_data_low");
    step(1, 32'h3000, 0, 0, 32'h2004, "R7_exec_only_t1");
    ctl0 = 32'h0000_0044; cmp0 = 32'h0000_3000;
    ctl1 = 32'h0000_0041; cmp1 = 32'h0000_2000;
    step(1, 32'h3000, 1, 0, 32'h2004, "R7_exec_low");
    step(0, '0, 1, 0, 32'h2004, "R7_data_only_t1");
    step(0, '0, 0, 0, '0, "R8_pulse_end");
    chk("R9_cause_idle", 32'(cause), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule